// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block sits at the front of an Ethernet receive path and decides whether an incoming frame is for this station. The receive logic feeds it the six destination address bytes, one per valid cycle, with the first byte flagged as the start of a frame. Software programs a 48-bit station address and two 64-bit hash tables through a small register port. One table is used for individual (unicast) destinations and the other for group (multicast and broadcast) destinations.

Each address byte goes through one unrolled 8-bit step of a reflected CRC-32. The CRC starts from all ones at every frame start. The six most significant bits of the final CRC pick one bit of the table that applies to the address. The same pass compares each byte against the programmed station address. One cycle after the sixth byte, the block reports its decision: the frame is accepted when the address equals the station address or when the selected table bit is set. Along with the decision it reports the hash index, the exact-match flag and the group flag.

Top module: `addr_hash_filter`

## Requirements
- R1: After reset, flt_done, flt_accept and flt_exact are 0, every configuration word reads 0, and the low half of word 1 reads 16'h8808.
- R2: Word 0 holds station bytes 0..3, with byte 0 in bits [31:24] down to byte 3 in [7:0]. Word 1 holds byte 4 in bits [31:24] and byte 5 in [23:16]. Bits [15:0] of word 1 always read 16'h8808 and ignore writes.
- R3: The CRC starts at 32'hFFFFFFFF when a byte arrives with rx_sof. Bytes 0..5 are taken in order, each least significant bit first. Each bit step XORs the data bit with CRC bit 0, shifts the CRC right by one, and XORs in 32'hEDB88320 when that XOR was 1. flt_hash_idx equals the final CRC shifted right by 26.
- R4: Index values 32..63 select bit (index-32) of the upper table word, and values 0..31 select bit index of the lower word. The individual table has its upper word at address 2 and its lower word at address 3. The group table has its upper word at address 4 and its lower word at address 5.
- R5: An address whose byte 0 has bit 0 set is a group address. flt_group is 1 for it, and only the group table is consulted. For any other address only the individual table is consulted.
- R6: flt_exact is 1 exactly when all six received bytes equal the programmed station bytes.
- R7: flt_accept equals flt_exact OR the selected table bit while flt_done is 1. flt_accept and flt_exact are 0 while flt_done is 0.
- R8: flt_done is high for one cycle, in the cycle after the sixth counted byte. Cycles with rx_valid low do not count as bytes. Further bytes are ignored until the next byte that arrives with rx_sof.
- R9: A byte arriving with rx_sof restarts the address at byte 0 and discards any partial address, so only the restarted address produces a decision.
- R10: Writes to configuration addresses 6 and 7 change nothing, and those addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_waddr | input | 3 | Configuration write word address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_raddr | input | 3 | Configuration read word address |
| cfg_rdata | output | 32 | Configuration read data (combinational) |
| rx_sof | input | 1 | Marks the current byte as destination byte 0 |
| rx_valid | input | 1 | Byte on rx_byte is valid this cycle |
| rx_byte | input | 8 | Destination address byte |
| flt_done | output | 1 | One-cycle decision strobe |
| flt_accept | output | 1 | Frame accepted |
| flt_exact | output | 1 | Station address matched |
| flt_group | output | 1 | Address was a group address |
| flt_hash_idx | output | 6 | Hash index used for the decision |

## Verification
A corrupted CRC state shows up in flt_hash_idx in the decision cycle, one cycle after the sixth byte, so the bench compares the index with a bit-level reference on every address it sends. A wrong byte count or a missed restart shows as a missing, extra or early flt_done pulse, which a pulse counter catches across frames that contain gaps, extra bytes and aborted starts. A wrong table-word or group selection changes flt_accept only for certain addresses. For that reason, single-bit and all-but-one-bit tables are built around a known index for both a unicast and a multicast address.

// File: rtl/ahf_pkg.sv
package ahf_pkg;
    localparam int BYTE_W     = 8;
    localparam int ADDR_BYTES = 6;
    localparam int MAC_W      = BYTE_W * ADDR_BYTES;
    localparam int REG_W      = 32;
    localparam int CRC_W      = 32;
    localparam int HASH_BITS  = 6;
    localparam int TBL_BITS   = 1 << HASH_BITS;
    localparam int TBL_WORDS  = TBL_BITS / REG_W;
    localparam int CNT_W      = $clog2(ADDR_BYTES + 1);

    localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;
    localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFFFFFF;
    localparam logic [15:0]      STN_PAD  = 16'h8808;

    // configuration word map
    localparam int STN_HI_A = 0;
    localparam int STN_LO_A = 1;
    localparam int IND_A    = 2;
    localparam int GRP_A    = IND_A + TBL_WORDS;

    // one reflected CRC step for a single data bit
    function automatic logic [CRC_W-1:0] crc_bit_step(input logic [CRC_W-1:0] c,
                                                       input logic b);
        logic [CRC_W-1:0] r;
        r = c >> 1;
        if (c[0] ^ b)
            r = r ^ CRC_POLY;
        return r;
    endfunction
endpackage

// File: rtl/ahf_cfg_regs.sv
module ahf_cfg_regs
    import ahf_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [AW-1:0]        waddr,
    input  logic [REG_W-1:0]     wdata,
    input  logic [AW-1:0]        raddr,
    output logic [REG_W-1:0]     rdata,
    output logic [MAC_W-1:0]     station,
    output logic [TBL_BITS-1:0]  ind_tbl,
    output logic [TBL_BITS-1:0]  grp_tbl
);
    typedef struct packed {
        logic [REG_W-1:0]                 stn_hi;
        logic [15:0]                      stn_lo;
        logic [TBL_WORDS-1:0][REG_W-1:0]  ind;
        logic [TBL_WORDS-1:0][REG_W-1:0]  grp;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            if (waddr == AW'(STN_HI_A))
                st_d.stn_hi = wdata;
            if (waddr == AW'(STN_LO_A))
                st_d.stn_lo = wdata[REG_W-1 -: 16];
            for (int w = 0; w < TBL_WORDS; w++) begin
                if (waddr == AW'(IND_A + TBL_WORDS - 1 - w))
                    st_d.ind[w] = wdata;
                if (waddr == AW'(GRP_A + TBL_WORDS - 1 - w))
                    st_d.grp[w] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        if (raddr == AW'(STN_HI_A))
            rdata = st_q.stn_hi;
        if (raddr == AW'(STN_LO_A))
            rdata = {st_q.stn_lo, STN_PAD};
        for (int w = 0; w < TBL_WORDS; w++) begin
            if (raddr == AW'(IND_A + TBL_WORDS - 1 - w))
                rdata = st_q.ind[w];
            if (raddr == AW'(GRP_A + TBL_WORDS - 1 - w))
                rdata = st_q.grp[w];
        end
    end

    assign station = {st_q.stn_hi, st_q.stn_lo};
    assign ind_tbl = st_q.ind;
    assign grp_tbl = st_q.grp;
endmodule

// File: rtl/ahf_crc_unit.sv
module ahf_crc_unit
    import ahf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              first,
    input  logic [BYTE_W-1:0] din,
    output logic [CRC_W-1:0]  crc_nxt
);
    typedef struct packed {
        logic [CRC_W-1:0] crc;
    } crc_st_t;

    crc_st_t st_d, st_q;
    logic [CRC_W-1:0] chain [0:BYTE_W];

    assign chain[0] = first ? CRC_SEED : st_q.crc;

    // one unrolled bit step per data bit, least significant bit first
    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
        assign chain[i+1] = crc_bit_step(chain[i], din[i]);
    end

    always_comb begin
        st_d = st_q;
        if (take)
            st_d.crc = chain[BYTE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '{crc: CRC_SEED};
        else
            st_q <= st_d;
    end

    assign crc_nxt = st_d.crc;
endmodule

// File: rtl/ahf_addr_track.sv
module ahf_addr_track
    import ahf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof,
    input  logic              valid,
    input  logic [BYTE_W-1:0] din,
    input  logic [MAC_W-1:0]  station,
    output logic              take,
    output logic              first,
    output logic              last,
    output logic              exact_nxt,
    output logic              group_nxt
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             eq;
        logic             grp;
    } trk_t;

    trk_t st_d, st_q;
    logic [CNT_W-1:0]  pos;
    logic [BYTE_W-1:0] stn_sel;
    logic [BYTE_W-1:0] stn_b [ADDR_BYTES];

    for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_stn
        assign stn_b[k] = station[MAC_W-1-BYTE_W*k -: BYTE_W];
    end

    always_comb begin
        first = valid && sof;
        pos   = first ? '0 : st_q.cnt;
        take  = valid && (pos < CNT_W'(ADDR_BYTES));
        last  = take && (pos == CNT_W'(ADDR_BYTES - 1));
        stn_sel = '0;
        for (int k = 0; k < ADDR_BYTES; k++)
            if (pos == CNT_W'(k))
                stn_sel = stn_b[k];
        st_d = st_q;
        if (take) begin
            st_d.cnt = pos + 1'b1;
            st_d.eq  = (first ? 1'b1 : st_q.eq) && (din == stn_sel);
            st_d.grp = first ? din[0] : st_q.grp;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '{cnt: CNT_W'(ADDR_BYTES), eq: 1'b0, grp: 1'b0};
        else
            st_q <= st_d;
    end

    assign exact_nxt = st_d.eq;
    assign group_nxt = st_d.grp;
endmodule

// File: rtl/addr_hash_filter.sv
module addr_hash_filter
    import ahf_pkg::*;
#(
    parameter int CFG_AW = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CFG_AW-1:0]    cfg_waddr,
    input  logic [REG_W-1:0]     cfg_wdata,
    input  logic [CFG_AW-1:0]    cfg_raddr,
    output logic [REG_W-1:0]     cfg_rdata,
    input  logic                 rx_sof,
    input  logic                 rx_valid,
    input  logic [BYTE_W-1:0]    rx_byte,
    output logic                 flt_done,
    output logic                 flt_accept,
    output logic                 flt_exact,
    output logic                 flt_group,
    output logic [HASH_BITS-1:0] flt_hash_idx
);
    typedef struct packed {
        logic                 done;
        logic                 accept;
        logic                 exact;
        logic                 group;
        logic [HASH_BITS-1:0] idx;
    } dec_t;

    logic [MAC_W-1:0]     station;
    logic [TBL_BITS-1:0]  ind_tbl, grp_tbl, sel_tbl;
    logic [CRC_W-1:0]     crc_nxt;
    logic                 take, first, last, exact_nxt, group_nxt;
    logic [HASH_BITS-1:0] hidx;
    dec_t                 dec_d, dec_q;

    ahf_cfg_regs #(.AW(CFG_AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .waddr   (cfg_waddr),
        .wdata   (cfg_wdata),
        .raddr   (cfg_raddr),
        .rdata   (cfg_rdata),
        .station (station),
        .ind_tbl (ind_tbl),
        .grp_tbl (grp_tbl)
    );

    ahf_addr_track u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .sof       (rx_sof),
        .valid     (rx_valid),
        .din       (rx_byte),
        .station   (station),
        .take      (take),
        .first     (first),
        .last      (last),
        .exact_nxt (exact_nxt),
        .group_nxt (group_nxt)
    );

    ahf_crc_unit u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .first   (first),
        .din     (rx_byte),
        .crc_nxt (crc_nxt)
    );

    assign hidx    = crc_nxt[CRC_W-1 -: HASH_BITS];
    assign sel_tbl = group_nxt ? grp_tbl : ind_tbl;

    always_comb begin
        dec_d = '0;
        if (last) begin
            dec_d.done   = 1'b1;
            dec_d.exact  = exact_nxt;
            dec_d.group  = group_nxt;
            dec_d.idx    = hidx;
            dec_d.accept = exact_nxt | sel_tbl[hidx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dec_q <= '0;
        else
            dec_q <= dec_d;
    end

    assign flt_done     = dec_q.done;
    assign flt_accept   = dec_q.accept;
    assign flt_exact    = dec_q.exact;
    assign flt_group    = dec_q.group;
    assign flt_hash_idx = dec_q.idx;
endmodule

// File: rtl/ahf_checker.sv
module ahf_checker #(
    parameter int AW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_sof,
    input logic          rx_valid,
    input logic [AW-1:0] cfg_raddr,
    input logic [31:0]   cfg_rdata,
    input logic          flt_done,
    input logic          flt_accept,
    input logic          flt_exact
);
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flt_done |=> !flt_done);

    p_done_after_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flt_done |-> $past(rx_valid));

    p_quiet_outputs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_done |-> (!flt_accept && !flt_exact));

    p_exact_accepts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flt_exact |-> flt_accept);

    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_sof && rx_valid) |=> !flt_done);

    p_pad_const_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_raddr == AW'(1)) |-> (cfg_rdata[15:0] == 16'h8808));
endmodule

bind addr_hash_filter ahf_checker #(.AW(CFG_AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_sof     (rx_sof),
    .rx_valid   (rx_valid),
    .cfg_raddr  (cfg_raddr),
    .cfg_rdata  (cfg_rdata),
    .flt_done   (flt_done),
    .flt_accept (flt_accept),
    .flt_exact  (flt_exact)
);

// File: tb/sim_addr_hash_filter.sv
module sim_addr_hash_filter;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 50000;

    localparam logic [47:0] STN   = 48'h02_11_22_33_44_55;
    localparam logic [63:0] IND_T = 64'h9E37_79B9_7F4A_7C15;
    localparam logic [63:0] GRP_T = 64'hC2B2_AE3D_27D4_EB4F;
    localparam int NVEC = 8;
    localparam logic [47:0] VEC [NVEC] = '{
        48'h02_11_22_33_44_55, 48'h02_11_22_33_44_54, 48'h00_00_00_00_00_00,
        48'hFF_FF_FF_FF_FF_FF, 48'h01_00_5E_00_00_01, 48'h33_33_00_00_00_01,
        48'h02_00_00_00_00_01, 48'hAA_BB_CC_DD_EE_F0
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_waddr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [2:0]  cfg_raddr = '0;
    logic [31:0] cfg_rdata;
    logic        rx_sof = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        flt_done, flt_accept, flt_exact, flt_group;
    logic [5:0]  flt_hash_idx;

    int n_chk = 0;
    int n_err = 0;
    int done_cnt = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_hash_filter u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
        .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
        .rx_sof(rx_sof), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .flt_done(flt_done), .flt_accept(flt_accept), .flt_exact(flt_exact),
        .flt_group(flt_group), .flt_hash_idx(flt_hash_idx)
    );

    always @(negedge clk) if (flt_done) done_cnt++;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] ref_idx(input logic [47:0] a);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int k = 0; k < 6; k++) begin
            logic [7:0] b = a[47-8*k -: 8];
            for (int j = 0; j < 8; j++) begin
                if (c[0] ^ b[j]) c = (c >> 1) ^ 32'hEDB88320;
                else             c = c >> 1;
            end
        end
        return c[31:26];
    endfunction

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_waddr = 3'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        cfg_raddr = 3'(a);
        #1 d = cfg_rdata;
    endtask

    task automatic set_tbls(input logic [63:0] it, input logic [63:0] gt);
        wr(2, it[63:32]); wr(3, it[31:0]);
        wr(4, gt[63:32]); wr(5, gt[31:0]);
    endtask

    task automatic send_byte(input logic s, input logic [7:0] b);
        @(negedge clk);
        rx_sof = s; rx_valid = 1'b1; rx_byte = b;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_sof = 1'b0; rx_valid = 1'b0;
        end
    endtask

    // sends six bytes; returns at the negedge where the decision is visible
    task automatic send_addr(input logic [47:0] a);
        for (int k = 0; k < 6; k++) send_byte(k == 0, a[47-8*k -: 8]);
        idle(1);
        #1;
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [5:0]  ix;
        int          c0;
        logic [63:0] one;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R10 unused words
        #1;
        chk("R1 done", flt_done, 0);
        chk("R1 accept", flt_accept, 0);
        for (int a = 0; a < 8; a++) begin
            rd(a, d);
            chk(a >= 6 ? "R10 reset read" : "R1 reset read", d, (a == 1) ? 32'h8808 : 32'h0);
        end

        // R2 station layout and fixed low half
        wr(0, STN[47:16]);
        wr(1, {STN[15:0], 16'hDEAD});
        rd(0, d); chk("R2 word0", d, STN[47:16]);
        rd(1, d); chk("R2 word1", d, {STN[15:0], 16'h8808});

        // R10 writes to unused addresses change nothing
        wr(6, 32'hFFFF_FFFF); wr(7, 32'hFFFF_FFFF);
        rd(6, d); chk("R10 read6", d, 0);
        rd(7, d); chk("R10 read7", d, 0);
        rd(0, d); chk("R10 word0 kept", d, STN[47:16]);
        rd(2, d); chk("R10 word2 kept", d, 0);

        // vector walk: R3 R5 R6 R7 R8
        set_tbls(IND_T, GRP_T);
        for (int v = 0; v < NVEC; v++) begin
            logic [47:0] a = VEC[v];
            logic        g = a[40];
            logic [63:0] t = g ? GRP_T : IND_T;
            logic        ex = (a == STN);
            ix = ref_idx(a);
            send_addr(a);
            chk("R8 done", flt_done, 1);
            chk("R3 hash idx", flt_hash_idx, ix);
            chk("R5 group", flt_group, g);
            chk("R6 exact", flt_exact, ex);
            chk("R7 accept", flt_accept, ex | t[ix]);
            idle(1); #1;
            chk("R8 single pulse", flt_done, 0);
        end

        // R4 word and bit selection, unicast
        ix = ref_idx(48'h02_00_00_00_00_07);
        one = 64'd1 << ix;
        set_tbls(one, 64'h0);
        send_addr(48'h02_00_00_00_00_07);
        chk("R4 single bit hit", flt_accept, 1);
        set_tbls(~one, 64'h0);
        send_addr(48'h02_00_00_00_00_07);
        chk("R4 all but bit miss", flt_accept, 0);
        set_tbls(64'h0, ~64'h0);
        send_addr(48'h02_00_00_00_00_07);
        chk("R5 unicast ignores group table", flt_accept, 0);

        // R5 group address uses group table only
        ix = ref_idx(48'h01_00_5E_01_02_03);
        one = 64'd1 << ix;
        set_tbls(~64'h0, 64'h0);
        send_addr(48'h01_00_5E_01_02_03);
        chk("R5 group ignores individual table", flt_accept, 0);
        set_tbls(64'h0, one);
        send_addr(48'h01_00_5E_01_02_03);
        chk("R4 group single bit hit", flt_accept, 1);
        chk("R5 group flag", flt_group, 1);
        set_tbls(64'h0, ~one);
        send_addr(48'h01_00_5E_01_02_03);
        chk("R4 group all but bit miss", flt_accept, 0);

        // R9 restart discards partial address
        set_tbls(64'h0, 64'h0);
        idle(2);
        c0 = done_cnt;
        send_byte(1'b1, 8'h02); send_byte(1'b0, 8'h11); send_byte(1'b0, 8'h22);
        send_addr(48'h02_00_00_00_00_07);
        chk("R9 one decision", done_cnt - c0, 1);
        chk("R9 restarted idx", flt_hash_idx, ref_idx(48'h02_00_00_00_00_07));
        send_byte(1'b1, 8'h02); send_byte(1'b0, 8'h11); send_byte(1'b0, 8'h22);
        send_byte(1'b0, 8'h33); send_byte(1'b0, 8'h44);
        send_addr(STN);
        chk("R9 exact after restart", flt_exact, 1);

        // R8 gaps in rx_valid and extra bytes
        idle(2);
        c0 = done_cnt;
        for (int k = 0; k < 6; k++) begin
            send_byte(k == 0, STN[47-8*k -: 8]);
            idle(2);
        end
        chk("R8 gaps one decision", done_cnt - c0, 1);
        for (int k = 0; k < 8; k++) send_byte(1'b0, 8'h5A);
        idle(2);
        chk("R8 extra bytes ignored", done_cnt - c0, 1);
        send_addr(STN);
        chk("R6 gapped then exact", flt_exact, 1);

        idle(2);
        finish_run();
    end
endmodule